// File: doc/BRIEF.md
# Region Verification Timer Buffer

This block decides when an executed code region can be trusted. A soft-error detector in the core has a fixed worst-case reporting latency. Code runs as a stream of regions. Each region is closed by a boundary instruction. That boundary, and every store before it, counts as verified once the full detection latency has passed since the boundary committed without an error report. The block keeps a small circular queue of boundary records. Each record holds three things: the boundary's PC, the store-queue tail pointer at that moment, and the length of the region that the boundary closed.

The block does not keep a full timestamp in every record. It uses one shared countdown, which holds the cycles left until the oldest record is verified. It also uses one auxiliary count, which holds the spacing between the oldest and newest boundaries. When the countdown expires, three things happen: the oldest record is released, the store queue is told it may retire every store older than the record's pointer, and the record's PC becomes the recovery PC. When an error is reported, every pending record is discarded and a redirect to the recovery PC is requested. The block does not restore registers and does not flush the pipeline itself.

Top module: `region_verify_buffer`

## Requirements
- R1: After reset, no verify or redirect is issued, stall is low and recovery_pc equals the parameter RESET_PC.
- R2: If bnd_valid is sampled at rising edge k while the buffer is empty, verify_valid is high for one cycle, in the cycle that follows edge k+DLY, and is low in every cycle before it.
- R3: With several boundaries pending, the verifies come in commit order. Each boundary is verified in the cycle after edge k+DLY, where k is that boundary's own commit edge, and verify_ptr then carries the bnd_sq_tail value captured with it.
- R4: In the cycle after a verify, recovery_pc holds the PC of the boundary that was verified. In any other case, recovery_pc keeps its value.
- R5: In a cycle with err_valid high, redirect_valid is high and redirect_pc equals recovery_pc. That cycle issues no verify, recovery_pc is not changed, and a commit offered in that cycle is ignored. All pending boundaries are discarded and are never verified.
- R6: The buffer holds DEPTH boundaries. stall is high when all DEPTH slots are occupied and no verify occurs in that cycle, and a boundary offered while stall is high is dropped.
- R7: A commit in the same cycle as a verify is accepted, and the verify is processed first. The new boundary is verified DLY cycles after its own commit edge. If the verify left the buffer empty, the new boundary becomes the oldest record with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 1 | A region boundary commits this cycle |
| bnd_pc | input | PC_W | PC of the committing boundary |
| bnd_sq_tail | input | SQ_W | Store-queue tail pointer at the boundary |
| err_valid | input | 1 | Error-detected pulse |
| stall | output | 1 | Buffer full; a boundary would be dropped |
| verify_valid | output | 1 | Oldest boundary verified this cycle |
| verify_ptr | output | SQ_W | Stores older than this pointer are verified |
| recovery_pc | output | PC_W | PC of the most recently verified boundary |
| redirect_valid | output | 1 | Redirect request on error |
| redirect_pc | output | PC_W | Redirect target |

## Verification
Some properties are checked on every cycle:
- The countdown plus the auxiliary count never exceeds the latency while any record is pending.
- The occupancy never goes past DEPTH.
- After an error, the next cycle has neither a verify nor a stall.
- recovery_pc changes only after a verify, and then takes the PC of the record that was verified.

The bench scenarios cover the rest:
- The exact verify cycle, measured from each boundary's own commit edge and derived from that edge alone.
- The pointer order across irregular spacing.
- The records that are dropped while the buffer is full.
- The cases where an error or a commit lands in the very cycle of an expiry.

// File: rtl/region_verify_buffer.sv
module region_verify_buffer #(
  parameter int PC_W = 32,
  parameter int SQ_W = 6,
  parameter int DLY = 30,
  parameter int DEPTH = 14,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bnd_valid,
  input  logic [PC_W-1:0] bnd_pc,
  input  logic [SQ_W-1:0] bnd_sq_tail,
  input  logic            err_valid,
  output logic            stall,
  output logic            verify_valid,
  output logic [SQ_W-1:0] verify_ptr,
  output logic [PC_W-1:0] recovery_pc,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int TW = $clog2(DLY + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PC_W-1:0] pc_q  [DEPTH];
  logic [SQ_W-1:0] ptr_q [DEPTH];
  logic [TW-1:0]   rt_q  [DEPTH];
  logic [IW-1:0]   rd, wr;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   to_wait, has_waited;
  logic [PC_W-1:0] rec_pc;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + IW'(1);
  endfunction

  wire expire = (cnt != '0) && (to_wait == '0);
  wire full   = (cnt == CW'(DEPTH));
  assign stall          = full && !expire;
  assign verify_valid   = expire && !err_valid;
  assign verify_ptr     = ptr_q[rd];
  assign recovery_pc    = rec_pc;
  assign redirect_valid = err_valid;
  assign redirect_pc    = rec_pc;

  wire pop  = verify_valid;
  wire push = bnd_valid && !stall && !err_valid;

  wire [TW-1:0] rt_next = rt_q[nxt(rd)];
  wire [TW-1:0] tw_u    = (pop ? rt_next : to_wait) - TW'(1);
  wire [TW-1:0] hw_u    = pop ? has_waited - rt_next : has_waited;
  wire          empty_u = (cnt == '0) || (pop && cnt == CW'(1));
  wire [TW-1:0] rt_new  = empty_u ? '0 : TW'(DLY) - hw_u - tw_u;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd <= '0;
      wr <= '0;
      cnt <= '0;
      to_wait <= '0;
      has_waited <= '0;
      rec_pc <= RESET_PC;
    end else if (err_valid) begin
      rd <= wr;
      cnt <= '0;
      has_waited <= '0;
    end else begin
      if (pop) begin
        rd <= nxt(rd);
        rec_pc <= pc_q[rd];
      end
      if (push) wr <= nxt(wr);
      if (push && empty_u) begin
        to_wait <= TW'(DLY);
        has_waited <= '0;
      end else if (push) begin
        to_wait <= tw_u;
        has_waited <= TW'(DLY) - tw_u;
      end else if (cnt != '0) begin
        to_wait <= tw_u;
        has_waited <= hw_u;
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      pc_q[wr]  <= bnd_pc;
      ptr_q[wr] <= bnd_sq_tail;
      rt_q[wr]  <= rt_new;
    end
  end

  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ({1'b0, to_wait} + {1'b0, has_waited} <= (TW+1)'(DLY)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_err_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (!verify_valid && !stall));
  assert_rec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_valid |=> $stable(recovery_pc));
  assert_rec_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    verify_valid |=> (recovery_pc == $past(pc_q[rd])));
endmodule

// File: tb/region_verify_buffer_bench.sv
`timescale 1ns/1ps
module region_verify_buffer_bench;
  localparam int DLY = 30;
  localparam int DEPTH = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bnd_valid = 1'b0;
  logic [31:0] bnd_pc = '0;
  logic [5:0] bnd_sq_tail = '0;
  logic err_valid = 1'b0;
  logic stall, verify_valid, redirect_valid;
  logic [5:0] verify_ptr;
  logic [31:0] recovery_pc, redirect_pc;

  region_verify_buffer u_region_verify_buffer (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_pc(bnd_pc),
    .bnd_sq_tail(bnd_sq_tail), .err_valid(err_valid), .stall(stall),
    .verify_valid(verify_valid), .verify_ptr(verify_ptr),
    .recovery_pc(recovery_pc), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nver = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  int mq_cyc [64];
  logic [31:0] mq_pc [64];
  logic [5:0] mq_ptr [64];
  int mh = 0;
  int mt = 0;
  logic [31:0] mrec = '0;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      automatic int n = mt - mh;
      automatic bit exp_now = (n > 0) && (mq_cyc[mh % 64] + DLY == cyc);
      automatic bit exp_stall = (n == DEPTH) && !exp_now;
      check(verify_valid == (exp_now && !err_valid), "R2/R3 verify timing",
            longint'(verify_valid), longint'(exp_now && !err_valid));
      if (verify_valid && exp_now)
        check(verify_ptr == mq_ptr[mh % 64], "R3 verify_ptr", verify_ptr, mq_ptr[mh % 64]);
      check(recovery_pc == mrec, "R4 recovery_pc", recovery_pc, mrec);
      check(redirect_valid == err_valid, "R5 redirect_valid", redirect_valid, err_valid);
      if (err_valid) check(redirect_pc == mrec, "R5 redirect_pc", redirect_pc, mrec);
      check(stall == exp_stall, "R6 stall", stall, exp_stall);
      if (verify_valid) nver++;
      if (err_valid) mh = mt;
      else begin
        if (exp_now) begin
          mrec = mq_pc[mh % 64];
          mh++;
        end
        if (bnd_valid && !exp_stall) begin
          mq_cyc[mt % 64] = cyc + 1;
          mq_pc[mt % 64] = bnd_pc;
          mq_ptr[mt % 64] = bnd_sq_tail;
          mt++;
        end
      end
    end
  end

  task automatic commit(input logic [31:0] pc, input logic [5:0] ptr);
    @(negedge clk);
    bnd_valid = 1'b1; bnd_pc = pc; bnd_sq_tail = ptr;
    @(negedge clk);
    bnd_valid = 1'b0;
  endtask

  task automatic latency(output int m);
    m = 0;
    #2;
    while (!verify_valid && m < 3 * DLY) begin
      @(negedge clk); #2; m++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    idle(3);
    #2;
    check(verify_valid == 0, "R1 verify in reset", verify_valid, 0);
    check(stall == 0, "R1 stall in reset", stall, 0);
    check(recovery_pc == 0, "R1 recovery_pc in reset", recovery_pc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(redirect_valid == 0, "R1 redirect after reset", redirect_valid, 0);
    check(verify_valid == 0, "R1 verify after reset", verify_valid, 0);
  endtask

  task automatic t_single();
    int m;
    commit(32'h100, 6'd5);
    latency(m);
    check(m == DLY, "R2 single latency", m, DLY);
    check(verify_ptr == 6'd5, "R2 single ptr", verify_ptr, 5);
    @(negedge clk); #2;
    check(verify_valid == 0, "R2 one-cycle verify", verify_valid, 0);
    check(recovery_pc == 32'h100, "R4 recovery after single", recovery_pc, 32'h100);
  endtask

  task automatic t_multi();
    int v0 = nver;
    commit(32'h200, 6'd10);
    idle(1);
    commit(32'h204, 6'd12);
    idle(3);
    commit(32'h208, 6'd17);
    commit(32'h20c, 6'd18);
    idle(7);
    commit(32'h210, 6'd25);
    idle(DLY + 5);
    check(nver - v0 == 5, "R3 verify count", nver - v0, 5);
    check(recovery_pc == 32'h210, "R4 recovery after burst", recovery_pc, 32'h210);
  endtask

  task automatic t_full();
    int v0 = nver;
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      bnd_valid = 1'b1; bnd_pc = 32'h1000 + 32'(4 * i); bnd_sq_tail = 6'(i);
      #2;
      check(stall == (i >= DEPTH), "R6 stall when full", stall, i >= DEPTH);
    end
    @(negedge clk);
    bnd_valid = 1'b0;
    idle(DLY + 20);
    check(nver - v0 == DEPTH, "R6 dropped boundaries", nver - v0, DEPTH);
    check(recovery_pc == 32'h1000 + 32'(4 * (DEPTH - 1)), "R6 last kept pc",
          recovery_pc, 32'h1000 + 4 * (DEPTH - 1));
  endtask

  task automatic t_same_cycle();
    int m;
    int v0 = nver;
    commit(32'h300, 6'd1);
    idle(DLY);
    bnd_valid = 1'b1; bnd_pc = 32'h304; bnd_sq_tail = 6'd2;
    #2;
    check(verify_valid == 1, "R7 expiry with commit", verify_valid, 1);
    check(stall == 0, "R7 no stall", stall, 0);
    @(negedge clk);
    bnd_valid = 1'b0;
    latency(m);
    check(m == DLY, "R7 new head full latency", m, DLY);
    check(recovery_pc == 32'h300, "R7 older pc first", recovery_pc, 32'h300);
    commit(32'h400, 6'd3);
    idle(3);
    commit(32'h404, 6'd4);
    idle(DLY - 5);
    bnd_valid = 1'b1; bnd_pc = 32'h408; bnd_sq_tail = 6'd6;
    #2;
    check(verify_valid == 1, "R7 expiry with commit, two pending", verify_valid, 1);
    @(negedge clk);
    bnd_valid = 1'b0;
    idle(DLY + 3);
    check(nver - v0 == 5, "R7 verify count", nver - v0, 5);
    check(recovery_pc == 32'h408, "R7 final recovery", recovery_pc, 32'h408);
  endtask

  task automatic t_error();
    int m;
    int v0;
    logic [31:0] r0 = recovery_pc;
    commit(32'h500, 6'd7);
    idle(1);
    commit(32'h504, 6'd8);
    idle(5);
    err_valid = 1'b1;
    bnd_valid = 1'b1; bnd_pc = 32'h508; bnd_sq_tail = 6'd9;
    #2;
    check(redirect_valid == 1, "R5 redirect raised", redirect_valid, 1);
    check(redirect_pc == r0, "R5 redirect target", redirect_pc, r0);
    @(negedge clk);
    err_valid = 1'b0; bnd_valid = 1'b0;
    v0 = nver;
    idle(DLY + 5);
    check(nver - v0 == 0, "R5 pending discarded", nver - v0, 0);
    check(recovery_pc == r0, "R5 recovery kept", recovery_pc, r0);
    commit(32'h600, 6'd11);
    idle(DLY);
    err_valid = 1'b1;
    #2;
    check(verify_valid == 0, "R5 error wins over expiry", verify_valid, 0);
    @(negedge clk);
    err_valid = 1'b0;
    #2;
    check(recovery_pc == r0, "R5 no load on error expiry", recovery_pc, r0);
    commit(32'h700, 6'd13);
    latency(m);
    check(m == DLY, "R5 fresh start after error", m, DLY);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_full();
    t_same_cycle();
    t_error();
    idle(5);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule